// File: doc/BRIEF.md
# Multiplexed Performance Event Counter

This block measures hardware performance events with fewer physical counters than it has event inputs. A counter of its own counts clock cycles for the whole measurement. The event inputs are grouped into sets of two. Two shared counters serve one set at a time and are moved to the next set in round-robin order each time a programmable period of clock cycles ends. At every switch the shared counts and the cycle count are added into wide per-event accumulators. The block then adds one to the period tally of the set that just finished and one to the overall period tally. With these tallies, software can scale any event total to a full-duty estimate as raw × total ÷ active. Derived figures such as cycles per instruction or miss ratios are computed outside the block.

Events arrive as single-cycle pulses. Control is through plain single-cycle command pins (start, stop, clear), a period write strobe, and a combinational readback selector. There is no streaming data path, so no valid/ready handshake or back-pressure applies. Every pin is sampled on each rising edge, and a read returns the selected value in the same cycle.

Top module: `evmux_top`

## Requirements
- R1: After reset, the block is stopped (`running` low), `active_set` is 0, and every readback value is 0.
- R2: The cycle accumulator grows by exactly one for every clock edge at which the block is running, including the edge that samples a stop. It does not change while the block is stopped.
- R3: While running, the active set advances after every programmed period of clock cycles, in the order 0, 1, 2, 3, 0. The first switch comes on the period-th running edge after a start.
- R4: Event input s*2+j is counted only while set s is active, using shared slot j. Pulses on the inputs of the other sets have no effect.
- R5: A pulse that arrives on the edge where the sets switch is credited to the set that is leaving.
- R6: Every fold (a switch or a stop) adds one to the overall period tally and one to the tally of the set that was active.
- R7: A stop folds the partial counts and clears `running`. It does not move the active set, unless the stop falls on a switch edge. In that case the fold happens once and the set advances once.
- R8: A start while stopped resumes counting on the current set with a fresh period timer. Event pulses while stopped are ignored.
- R9: A clear zeroes every accumulator and tally and selects set 0 first. The period register is left untouched.
- R10: A period write takes effect only while stopped. A written value of 0 is stored as 1.
- R11: Readback select 0 returns the cycle accumulator. Selects 1 to 8 return event accumulators 0 to 7. Select 9 returns the overall period tally. Selects 10 to 13 return the tallies of sets 0 to 3. Any other select returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Begin or resume counting (one-cycle pulse) |
| cmd_stop | input | 1 | Fold partial counts and halt |
| cmd_clear | input | 1 | Zero accumulators, tallies and set pointer |
| period_we | input | 1 | Write strobe for the period register |
| period_in | input | PW (32) | Period length in clock cycles |
| event_in | input | NUM_SETS*PER_SET (8) | Event pulses; input s*2+j belongs to set s slot j |
| rd_sel | input | 4 | Readback select |
| rd_data | output | AW (64) | Selected accumulator or tally |
| running | output | 1 | High while counting |
| active_set | output | 2 | Set currently attached to the shared counters |

## Verification
The bench keeps the default four sets of two and the 32/64-bit widths, and programs a period of 8 cycles. This lets full rotations, the wrap from set 3 back to set 0, and stops both inside a period and on a switch edge all occur within a few dozen cycles. A written period of 0 (stored as 1) makes the set change on every edge, which places a switch on every event pulse. The 64-bit carry beyond 32 bits is not reached with these values.

// File: rtl/evmux_pkg.sv
package evmux_pkg;
  // Control strobes produced by the period controller each cycle.
  typedef struct packed {
    logic count_en;  // counters may advance this cycle
    logic fold;      // move counts into accumulators this cycle
  } evmux_ctl_t;

  // Fixed readback select codes; the rest derive from the set count.
  localparam int RD_CYCLES     = 0;
  localparam int RD_EVENT_BASE = 1;
endpackage

// File: rtl/evmux_ctrl.sv
module evmux_ctrl
  import evmux_pkg::*;
#(
  parameter int NUM_SETS       = 4,
  parameter int PW             = 32,
  parameter int DEFAULT_PERIOD = 1024,
  parameter int SW             = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_clear,
  input  logic          period_we,
  input  logic [PW-1:0] period_in,
  output logic          running,
  output logic [SW-1:0] cur_set,
  output logic [PW-1:0] period_q,
  output evmux_ctl_t    ctl
);
  logic [PW-1:0] tick_q;
  logic          strobe;
  logic          advance;

  assign strobe  = running && (tick_q == period_q - PW'(1));
  assign advance = ctl.count_en && strobe;

  always_comb begin
    ctl.count_en = running && !cmd_clear;
    ctl.fold     = ctl.count_en && (strobe || cmd_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      tick_q   <= '0;
      cur_set  <= '0;
      period_q <= PW'(DEFAULT_PERIOD);
    end else begin
      if (period_we && !running)
        period_q <= (period_in == '0) ? PW'(1) : period_in;
      if (cmd_clear) begin
        tick_q  <= '0;
        cur_set <= '0;
      end else begin
        if (running) begin
          tick_q <= ctl.fold ? '0 : tick_q + PW'(1);
          if (cmd_stop) running <= 1'b0;
        end else if (cmd_start) begin
          running <= 1'b1;
          tick_q  <= '0;
        end
        if (advance)
          cur_set <= (cur_set == SW'(NUM_SETS - 1)) ? '0 : cur_set + SW'(1);
      end
    end
  end
endmodule

// File: rtl/evmux_shared_cnt.sv
module evmux_shared_cnt #(
  parameter int PER_SET = 2,
  parameter int CW      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           count_en,
  input  logic                           fold,
  input  logic [PER_SET-1:0]             pulse,
  output logic [PER_SET-1:0][CW-1:0]     slot_fold,
  output logic [CW-1:0]                  cyc_fold,
  output logic [CW-1:0]                  cyc_count
);
  // Shared event counters, one per slot of the active set.
  for (genvar j = 0; j < PER_SET; j++) begin : g_slot
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clear || fold)    cnt_q <= '0;
      else if (count_en)         cnt_q <= cnt_q + CW'(pulse[j]);
    end
    // The value folded includes a pulse arriving on the fold cycle.
    assign slot_fold[j] = cnt_q + CW'(pulse[j]);
  end

  // Dedicated cycle counter, never multiplexed.
  logic [CW-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc_q <= '0;
    else if (clear || fold) cyc_q <= '0;
    else if (count_en)      cyc_q <= cyc_q + CW'(1);
  end
  assign cyc_fold  = cyc_q + CW'(1);
  assign cyc_count = cyc_q;
endmodule

// File: rtl/evmux_accum_bank.sv
module evmux_accum_bank #(
  parameter int NUM_SETS = 4,
  parameter int PER_SET  = 2,
  parameter int CW       = 32,
  parameter int AW       = 64,
  parameter int SW       = 2,
  localparam int NUM_EV  = NUM_SETS * PER_SET
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        fold,
  input  logic [SW-1:0]               cur_set,
  input  logic [PER_SET-1:0][CW-1:0]  slot_fold,
  input  logic [CW-1:0]               cyc_fold,
  output logic [NUM_EV-1:0][AW-1:0]   ev_acc,
  output logic [NUM_SETS-1:0][AW-1:0] act_acc,
  output logic [AW-1:0]               cyc_acc,
  output logic [AW-1:0]               total_acc
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    localparam int SET_I  = i / PER_SET;
    localparam int SLOT_I = i % PER_SET;
    logic [AW-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clear)  acc_q <= '0;
      else if (fold && cur_set == SW'(SET_I))
        acc_q <= acc_q + AW'(slot_fold[SLOT_I]);
    end
    assign ev_acc[i] = acc_q;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [AW-1:0] per_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_q <= '0;
      else if (clear)  per_q <= '0;
      else if (fold && cur_set == SW'(s))
        per_q <= per_q + AW'(1);
    end
    assign act_acc[s] = per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_acc   <= '0;
      total_acc <= '0;
    end else if (clear) begin
      cyc_acc   <= '0;
      total_acc <= '0;
    end else if (fold) begin
      cyc_acc   <= cyc_acc + AW'(cyc_fold);
      total_acc <= total_acc + AW'(1);
    end
  end
endmodule

// File: rtl/evmux_top.sv
module evmux_top
  import evmux_pkg::*;
#(
  parameter int NUM_SETS       = 4,
  parameter int PER_SET        = 2,
  parameter int CW             = 32,
  parameter int AW             = 64,
  parameter int PW             = 32,
  parameter int DEFAULT_PERIOD = 1024,
  localparam int NUM_EV        = NUM_SETS * PER_SET,
  localparam int SW            = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int RSW           = $clog2(NUM_EV + NUM_SETS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_clear,
  input  logic              period_we,
  input  logic [PW-1:0]     period_in,
  input  logic [NUM_EV-1:0] event_in,
  input  logic [RSW-1:0]    rd_sel,
  output logic [AW-1:0]     rd_data,
  output logic              running,
  output logic [SW-1:0]     active_set
);
  localparam int RD_TOTAL       = RD_EVENT_BASE + NUM_EV;
  localparam int RD_ACTIVE_BASE = RD_TOTAL + 1;

  evmux_ctl_t                   ctl;
  logic [PW-1:0]                period_q;
  logic [PER_SET-1:0]           act_pulse;
  logic [PER_SET-1:0][CW-1:0]   slot_fold;
  logic [CW-1:0]                cyc_fold;
  logic [CW-1:0]                cyc_phys;
  logic [NUM_EV-1:0][AW-1:0]    ev_acc;
  logic [NUM_SETS-1:0][AW-1:0]  act_acc;
  logic [AW-1:0]                cyc_acc;
  logic [AW-1:0]                total_acc;

  evmux_ctrl #(
    .NUM_SETS(NUM_SETS), .PW(PW), .DEFAULT_PERIOD(DEFAULT_PERIOD), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .period_we(period_we), .period_in(period_in),
    .running(running), .cur_set(active_set), .period_q(period_q), .ctl(ctl)
  );

  // Route the active set's inputs onto the shared slots.
  always_comb act_pulse = event_in[PER_SET * int'(active_set) +: PER_SET];

  evmux_shared_cnt #(.PER_SET(PER_SET), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cmd_clear), .count_en(ctl.count_en),
    .fold(ctl.fold), .pulse(act_pulse), .slot_fold(slot_fold),
    .cyc_fold(cyc_fold), .cyc_count(cyc_phys)
  );

  evmux_accum_bank #(
    .NUM_SETS(NUM_SETS), .PER_SET(PER_SET), .CW(CW), .AW(AW), .SW(SW)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(cmd_clear), .fold(ctl.fold),
    .cur_set(active_set), .slot_fold(slot_fold), .cyc_fold(cyc_fold),
    .ev_acc(ev_acc), .act_acc(act_acc), .cyc_acc(cyc_acc), .total_acc(total_acc)
  );

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) == RD_CYCLES) rd_data = cyc_acc;
    for (int i = 0; i < NUM_EV; i++)
      if (int'(rd_sel) == RD_EVENT_BASE + i) rd_data = ev_acc[i];
    if (int'(rd_sel) == RD_TOTAL) rd_data = total_acc;
    for (int s = 0; s < NUM_SETS; s++)
      if (int'(rd_sel) == RD_ACTIVE_BASE + s) rd_data = act_acc[s];
  end
endmodule

// File: rtl/evmux_checker.sv
module evmux_checker #(
  parameter int NUM_SETS = 4,
  parameter int CW       = 32,
  parameter int AW       = 64,
  parameter int PW       = 32,
  parameter int SW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_clear,
  input logic          running,
  input logic [SW-1:0] active_set,
  input logic [PW-1:0] period_q,
  input logic [CW-1:0] cyc_phys,
  input logic [AW-1:0] cyc_acc,
  input logic [AW-1:0] total_acc
);
  // R3: the set pointer only ever steps to its round-robin successor.
  a_r3_set_order: assert property (@(posedge clk) disable iff (!rst_n)
    (active_set != $past(active_set)) && !$past(cmd_clear) |->
      active_set == (($past(active_set) == SW'(NUM_SETS - 1)) ? SW'(0)
                                                              : $past(active_set) + SW'(1)));

  // R3: within a period the physical cycle counter stays below the period.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> AW'(cyc_phys) < AW'(period_q));

  // R6: the overall tally moves by at most one per cycle.
  a_r6_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_clear) |-> (total_acc == $past(total_acc)) ||
                          (total_acc == $past(total_acc) + AW'(1)));

  // R2: a stopped block leaves the cycle accumulator alone.
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(running) && !$past(cmd_clear) |-> $stable(cyc_acc));

  // R10: the period register cannot change while counting.
  a_r10_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> $stable(period_q));
endmodule

bind evmux_top evmux_checker #(
  .NUM_SETS(NUM_SETS), .CW(CW), .AW(AW), .PW(PW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .running(running),
  .active_set(active_set), .period_q(period_q), .cyc_phys(cyc_phys),
  .cyc_acc(cyc_acc), .total_acc(total_acc)
);

// File: tb/evmux_top_test.sv
`timescale 1ns/1ps
module evmux_top_test;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, cmd_stop, cmd_clear, period_we;
  logic [31:0] period_in;
  logic [NE-1:0] event_in;
  logic [3:0]  rd_sel;
  logic [63:0] rd_data;
  logic        running;
  logic [1:0]  active_set;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  evmux_top uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .period_we(period_we), .period_in(period_in),
    .event_in(event_in), .rd_sel(rd_sel), .rd_data(rd_data),
    .running(running), .active_set(active_set)
  );

  task automatic check(string req, string what, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic check_rd(string req, int sel, longint unsigned exp);
    rd_sel = 4'(sel);
    #0.2;
    check(req, $sformatf("readback sel %0d", sel), rd_data, exp);
  endtask

  task automatic write_period(int unsigned val);
    @(negedge clk); period_we = 1'b1; period_in = val;
    @(negedge clk); period_we = 1'b0;
  endtask

  // Leaves the bench just after the edge that sampled the start.
  task automatic do_start();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); cmd_clear = 1'b1;
    @(negedge clk); cmd_clear = 1'b0;
  endtask

  task automatic test_reset();
    check("R1", "running after reset", running, 0);
    check("R1", "set after reset", active_set, 0);
    for (int s = 0; s < 14; s++) check_rd("R1", s, 0);
  endtask

  // Four full periods of 8 plus a 3-cycle partial on set 0.
  task automatic test_rotation();
    write_period(8);
    event_in = '1;
    do_start();
    repeat (16) @(negedge clk);
    check("R3", "set after two periods", active_set, 2);
    repeat (18) @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    repeat (4) @(negedge clk);  // inputs stay high while stopped (R8)
    check("R7", "running after stop", running, 0);
    check("R7", "set kept by mid-period stop", active_set, 0);
    check_rd("R2", 0, 35);
    for (int i = 0; i < NE; i++) check_rd("R4", 1 + i, (i < 2) ? 11 : 8);
    check_rd("R6", 9, 5);
    check_rd("R6", 10, 2);
    for (int s = 1; s < 4; s++) check_rd("R6", 10 + s, 1);
  endtask

  // Resume on set 0; the stop lands on the switch edge.
  task automatic test_resume_stop_on_switch();
    do_start();
    repeat (7) @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0; event_in = '0;
    check("R8", "running after second stop", running, 0);
    check("R7", "set advanced once on coinciding stop", active_set, 1);
    check_rd("R8", 0, 43);
    check_rd("R8", 1, 19);
    check_rd("R8", 2, 19);
    check_rd("R8", 3, 8);
    check_rd("R7", 9, 6);
    check_rd("R7", 10, 3);
    check_rd("R7", 11, 1);
  endtask

  task automatic test_clear();
    do_clear();
    check("R9", "set after clear", active_set, 0);
    for (int s = 0; s < 14; s++) check_rd("R9", s, 0);
  endtask

  // Pulses on the switch edge go to set 0; a period write while running is dropped.
  task automatic test_switch_credit();
    event_in = '0;
    do_start();
    @(negedge clk); period_we = 1'b1; period_in = 3;
    @(negedge clk); period_we = 1'b0;
    repeat (5) @(negedge clk);
    event_in = '1;                 // sampled on the switch edge
    @(negedge clk);                // sampled on the first edge of set 1
    @(negedge clk); event_in = '0; cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    check("R10", "set after ignored period write", active_set, 1);
    check_rd("R10", 0, 10);
    check_rd("R5", 1, 1);
    check_rd("R5", 2, 1);
    check_rd("R5", 3, 1);
    check_rd("R5", 4, 1);
    for (int i = 4; i < NE; i++) check_rd("R4", 1 + i, 0);
    check_rd("R6", 9, 2);
    check_rd("R6", 10, 1);
    check_rd("R6", 11, 1);
    check_rd("R6", 12, 0);
    do_clear();
  endtask

  // A written period of 0 acts as 1: the set changes on every running edge.
  task automatic test_period_zero();
    write_period(0);
    event_in = '1;
    do_start();
    repeat (5) @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0; event_in = '0;
    check("R10", "set after six one-cycle periods", active_set, 2);
    check_rd("R10", 0, 6);
    check_rd("R3", 1, 2);
    check_rd("R3", 3, 2);
    check_rd("R3", 5, 1);
    check_rd("R3", 8, 1);
    check_rd("R3", 10, 2);
    check_rd("R3", 13, 1);
    check_rd("R11", 9, 6);
    check_rd("R11", 14, 0);
    check_rd("R11", 15, 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0; cmd_clear = 1'b0;
    period_we = 1'b0; period_in = '0; event_in = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rotation();
    test_resume_stop_on_switch();
    test_clear();
    test_switch_credit();
    test_period_zero();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule